// File: doc/BRIEF.md
# Clock-Synchronous Serial Shifter

This block is a byte-wide serial port that runs only as a clock-synchronous master. It sends a shift clock out on a clock pin and uses a single data line in both directions. A host starts a transfer with a one-cycle strobe and picks the direction with a select input. For a transmit it also supplies the byte. For a receive it reads the captured byte after the done flag rises.

All timing comes from the system clock. Each bit occupies a slot of eight system clock cycles. The shift clock is low for four cycles and high for four. Outgoing data changes two cycles after a rising edge, which puts it six cycles ahead of the next rising edge, and it is held until two cycles after that edge. Incoming data is captured on the same clock edge that raises the shift clock. The data line is driven only during a transmit. A full transfer takes 64 cycles, and bits move least significant first.

Top module: `ssp_sync_master`

## Requirements
- R1: During and after reset, with no transfer started, `sclk_o` is 1, `sdata_oe` is 0, `busy` is 0, `done` is 0 and `rx_byte` is 0.
- R2: A `start` pulse seen at a clock edge while idle sets `busy` and clears `done` from that edge onward. `busy` then stays 1 for the next 64 cycles.
- R3: Counting cycle c = 0 as the cycle that follows the accepting edge, `sclk_o` is 0 when c mod 8 is 2, 3, 4 or 5, and 1 otherwise, for c = 0..63. This gives eight low pulses of 4 cycles and high phases of 4 cycles. `sclk_o` is 1 whenever the block is idle.
- R4: In a transmit (`dir_tx` = 1), bit k of the byte is driven on `sdata_o` from cycle 8k onward, least significant bit first. Each bit therefore changes 6 cycles before its rising shift-clock edge at the start of cycle 8k+6.
- R5: A transmitted bit stays on `sdata_o` through cycles 8k+6 and 8k+7, which is 2 cycles after its rising edge.
- R6: `sdata_oe` is 1 for cycles 0..63 of a transmit. It is 0 throughout a receive and whenever the block is idle.
- R7: In a receive (`dir_tx` = 0), bit k is the value of `sdata_i` during cycle 8k+5, captured at the edge where `sclk_o` rises. Bits fill the byte least significant first, and the byte appears on `rx_byte` when `done` rises.
- R8: At the edge that ends cycle 63, `busy` falls and `done` rises. `done` stays 1 until the next accepted `start`.
- R9: A `start` pulse, or a change of `dir_tx` or `tx_byte`, while `busy` is 1 has no effect on the running transfer: not on its length, its clock, its data or its direction.
- R10: A transmit leaves `rx_byte` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one period is the timing unit |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer when idle |
| dir_tx | input | 1 | 1 = transmit, 0 = receive; sampled at start |
| tx_byte | input | DATA_W | Byte to transmit; sampled at start |
| rx_byte | output | DATA_W | Last received byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished; cleared by the next start |
| sclk_o | output | 1 | Shift clock, idles high |
| sdata_o | output | 1 | Serial data out |
| sdata_oe | output | 1 | Output enable for the shared data line |
| sdata_i | input | 1 | Serial data in from the shared data line |

## Verification
Errors in the phase or bit counters show up at once on `sclk_o`. A wrong phase moves a low pulse away from cycles 2..5 of its slot within the first slot, and a wrong bit count moves the fall of `busy` away from cycle 64. A slip in the transmit shifter shows up on `sdata_o` in the first slot after the slip. A receive that captures in the wrong cycle is exposed by the bench, which drives the true bit only in cycle 8k+5 and its inverse in every other cycle, so any such error corrupts `rx_byte` at the end of the transfer. A lost direction latch drives the data line during a receive, and this is visible on `sdata_oe` from cycle 0.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  // Per-cycle events raised by the bit timer for the shifter.
  typedef struct packed {
    logic go;      // start accepted this edge
    logic adv;     // next edge opens a new bit slot
    logic sample;  // next edge raises the shift clock
    logic finish;  // next edge ends the transfer
  } ssp_evt_t;

endpackage

// File: rtl/ssp_bit_timer.sv
module ssp_bit_timer #(
  parameter int DATA_W  = 8,
  parameter int HALF_TC = 4,
  parameter int LEAD_TC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy_o,
  output logic              sclk_o,
  output ssp_pkg::ssp_evt_t evt_o
);
  localparam int SLOT  = 2 * HALF_TC;
  localparam int PH_W  = $clog2(SLOT);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [PH_W-1:0]  PH_END  = PH_W'(SLOT - 1);
  localparam logic [PH_W-1:0]  PH_LOW  = PH_W'(LEAD_TC);
  localparam logic [PH_W-1:0]  PH_RISE = PH_W'(LEAD_TC + HALF_TC);
  localparam logic [PH_W-1:0]  PH_PRE  = PH_W'(LEAD_TC + HALF_TC - 1);
  localparam logic [BIT_W-1:0] BIT_END = BIT_W'(DATA_W - 1);

  logic [PH_W-1:0]  ph_q, ph_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             busy_q, busy_d, sclk_q, low_d;
  logic             go, slot_end, last_bit;

  assign go       = start && !busy_q;
  assign slot_end = busy_q && (ph_q == PH_END);
  assign last_bit = (bit_q == BIT_END);

  always_comb begin
    busy_d = busy_q;
    ph_d   = ph_q;
    bit_d  = bit_q;
    if (go) begin
      busy_d = 1'b1;
      ph_d   = '0;
      bit_d  = '0;
    end else if (busy_q) begin
      if (ph_q == PH_END) begin
        ph_d = '0;
        if (last_bit) busy_d = 1'b0;
        else          bit_d  = bit_q + 1'b1;
      end else begin
        ph_d = ph_q + 1'b1;
      end
    end
    low_d = busy_d && (ph_d >= PH_LOW) && (ph_d < PH_RISE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
      bit_q  <= '0;
      sclk_q <= 1'b1;
    end else begin
      busy_q <= busy_d;
      ph_q   <= ph_d;
      bit_q  <= bit_d;
      sclk_q <= !low_d;
    end
  end

  assign busy_o        = busy_q;
  assign sclk_o        = sclk_q;
  assign evt_o.go      = go;
  assign evt_o.adv     = slot_end && !last_bit;
  assign evt_o.sample  = busy_q && (ph_q == PH_PRE);
  assign evt_o.finish  = slot_end && last_bit;

  // R3
  sclk_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> sclk_o);

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q && start && (ph_q != PH_END) |=> busy_q && (ph_q == $past(ph_q) + 1'b1));

endmodule

// File: rtl/ssp_shift_unit.sv
module ssp_shift_unit #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ssp_pkg::ssp_evt_t evt,
  input  logic              busy,
  input  logic              sclk,
  input  logic              dir_tx,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              sdata_i,
  output logic              sdata_o,
  output logic              sdata_oe,
  output logic [DATA_W-1:0] rx_byte,
  output logic              done
);
  logic [DATA_W-1:0] tx_sh, rx_sh, rx_q;
  logic              dout_q, oe_q, dir_q, done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh  <= '0;
      rx_sh  <= '0;
      rx_q   <= '0;
      dout_q <= 1'b1;
      oe_q   <= 1'b0;
      dir_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (evt.go) begin
        tx_sh  <= tx_byte >> 1;
        dout_q <= dir_tx ? tx_byte[0] : 1'b1;
        oe_q   <= dir_tx;
        dir_q  <= dir_tx;
        done_q <= 1'b0;
      end
      if (evt.adv) begin
        tx_sh  <= tx_sh >> 1;
        dout_q <= dir_q ? tx_sh[0] : 1'b1;
      end
      if (evt.sample) begin
        rx_sh <= {sdata_i, rx_sh[DATA_W-1:1]};
      end
      if (evt.finish) begin
        dout_q <= 1'b1;
        oe_q   <= 1'b0;
        done_q <= 1'b1;
        if (!dir_q) rx_q <= rx_sh;
      end
    end
  end

  assign sdata_o  = dout_q;
  assign sdata_oe = oe_q;
  assign rx_byte  = rx_q;
  assign done     = done_q;

  // R6
  oe_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    sdata_oe |-> busy);

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy && !sclk |=> $stable(sdata_o));

  // R8
  done_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $fell(busy));

  // R10
  rx_kept_on_tx_chk: assert property (@(posedge clk) disable iff (rst)
    dir_q && busy |=> $stable(rx_byte));

endmodule

// File: rtl/ssp_sync_master.sv
module ssp_sync_master #(
  parameter int DATA_W  = 8,
  parameter int HALF_TC = 4,
  parameter int LEAD_TC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              dir_tx,
  input  logic [DATA_W-1:0] tx_byte,
  output logic [DATA_W-1:0] rx_byte,
  output logic              busy,
  output logic              done,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              sdata_oe,
  input  logic              sdata_i
);
  ssp_pkg::ssp_evt_t evt;

  ssp_bit_timer #(
    .DATA_W (DATA_W),
    .HALF_TC(HALF_TC),
    .LEAD_TC(LEAD_TC)
  ) i_timer (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy_o(busy),
    .sclk_o(sclk_o),
    .evt_o (evt)
  );

  ssp_shift_unit #(
    .DATA_W(DATA_W)
  ) i_shift (
    .clk     (clk),
    .rst     (rst),
    .evt     (evt),
    .busy    (busy),
    .sclk    (sclk_o),
    .dir_tx  (dir_tx),
    .tx_byte (tx_byte),
    .sdata_i (sdata_i),
    .sdata_o (sdata_o),
    .sdata_oe(sdata_oe),
    .rx_byte (rx_byte),
    .done    (done)
  );

endmodule

// File: tb/test_ssp_sync_master.sv
module test_ssp_sync_master;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       dir_tx = 1'b0;
  logic [7:0] tx_byte = '0;
  logic [7:0] rx_byte;
  logic       busy, done, sclk_o, sdata_o, sdata_oe;
  logic       sdata_i = 1'b1;

  int         n_chk = 0;
  int         n_fail = 0;
  bit         ended = 1'b0;
  logic [7:0] rx_model = '0;

  always #5 clk = ~clk;

  ssp_sync_master i_ssp_sync_master (
    .clk(clk), .rst(rst), .start(start), .dir_tx(dir_tx), .tx_byte(tx_byte),
    .rx_byte(rx_byte), .busy(busy), .done(done), .sclk_o(sclk_o),
    .sdata_o(sdata_o), .sdata_oe(sdata_oe), .sdata_i(sdata_i)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_sclk(int c);
    return !((c % 8) >= 2 && (c % 8) < 6);
  endfunction

  function automatic bit exp_rx_drive(logic [7:0] rxd, int c);
    return ((c % 8) == 5) ? rxd[c/8] : ~rxd[c/8];
  endfunction

  task automatic xfer(bit dir, logic [7:0] txd, logic [7:0] rxd, bit poke);
    logic [7:0] exp_rx;
    exp_rx = dir ? rx_model : rxd;
    @(negedge clk);
    start = 1'b1; dir_tx = dir; tx_byte = txd;
    @(posedge clk);
    for (int c = 0; c < 64; c++) begin
      @(negedge clk);
      if (c == 0) begin
        start = 1'b0;
        chk("R2 done cleared at start", done, 0);
      end
      if (poke && c == 20) begin
        start = 1'b1; dir_tx = ~dir; tx_byte = ~txd;
      end
      if (poke && c == 21) start = 1'b0;
      chk(poke ? "R9 R3 sclk under mid-start" : "R3 sclk shape", sclk_o, exp_sclk(c));
      chk("R2 busy held", busy, 1);
      chk("R6 output enable", sdata_oe, dir);
      if (dir) begin
        if ((c % 8) >= 6) chk("R5 tx hold after rise", sdata_o, txd[c/8]);
        else              chk("R4 tx bit lsb first", sdata_o, txd[c/8]);
      end
      sdata_i = exp_rx_drive(rxd, c);
    end
    @(negedge clk);
    chk("R8 busy falls", busy, 0);
    chk("R8 done rises", done, 1);
    chk(dir ? "R10 rx kept on tx" : "R7 rx byte", rx_byte, exp_rx);
    chk("R3 sclk idle high", sclk_o, 1);
    chk("R6 oe idle low", sdata_oe, 0);
    rx_model = exp_rx;
    repeat (5) @(negedge clk);
    chk("R8 done sticky", done, 1);
    chk("R8 still idle", busy, 0);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset sclk", sclk_o, 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle busy", busy, 0);
    chk("R1 idle done", done, 0);
    chk("R1 idle sclk", sclk_o, 1);
    chk("R1 idle oe", sdata_oe, 0);
    chk("R1 idle rx", rx_byte, 0);
    // directed corners
    xfer(1'b1, 8'h01, 8'h00, 1'b0);
    xfer(1'b1, 8'h80, 8'hff, 1'b0);
    xfer(1'b0, 8'h00, 8'ha5, 1'b0);
    xfer(1'b0, 8'hff, 8'h01, 1'b1);
    xfer(1'b1, 8'h3c, 8'h5a, 1'b1);
    xfer(1'b0, 8'h00, 8'h80, 1'b0);
    // constrained random
    for (int i = 0; i < 14; i++) begin
      xfer(1'($urandom), 8'($urandom), 8'($urandom), ($urandom % 4) == 0);
    end
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule